// File: doc/BRIEF.md
# Dual-Width Integer ALU for a Virtual Machine Core

This block executes the arithmetic group of a register-based virtual machine instruction set on 64-bit values. Each request carries a four-bit operation code, a bit choosing the second operand (the source register or the 32-bit immediate), a width flag that chooses the 64-bit class or the 32-bit class, the destination register value, the source register value, the immediate and an enable for the extended operation set. The block returns the new destination value. It also raises a flag when the combination of operation, width and mode is not legal.

The block covers addition, subtraction, multiplication, the bitwise operations, the three shifts, copy, negation and byte-order conversion. These complete in one cycle. Unsigned and signed division and remainder run on a shared iterative divider that resolves one quotient bit per cycle. A `start` pulse launches a request and a one-cycle `done` pulse marks its completion. The result and the illegal flag are held until the next completion. Register file access, instruction decode and condition flags belong to neighbouring blocks.

Top module: `vmx_int_alu`

## Requirements
- R1: After reset, `done`, `illegal` and `result` are all zero.
- R2: Operation codes are ADD=0, SUB=1, MUL=2, UDIV=3, OR=4, AND=5, SHL=6, SHR=7, NEG=8, UREM=9, XOR=10, COPY=11, SAR=12, BSWAP=13, SDIV=14, SREM=15. With `use_reg`=1 the second operand is `src_val`. With `use_reg`=0 it is `imm_val`, sign-extended to 64 bits in the 64-bit class.
- R3: In the 64-bit class (`wide`=1), ADD, SUB, MUL (low 64 bits), OR, AND and XOR combine the destination with the second operand. COPY returns the second operand and NEG returns the two's complement of the destination.
- R4: In the 32-bit class (`wide`=0), both operands are cut to their low 32 bits. Every operation except BSWAP returns its 32-bit result with bits 63:32 cleared.
- R5: SHL and SHR are logical shifts and SAR is arithmetic. The shift count is the low 6 bits of the second operand in the 64-bit class and its low 5 bits in the 32-bit class.
- R6: BSWAP takes its width (16, 32 or 64) from `imm_val` and works on the full 64-bit destination. With `use_reg`=0 it keeps the low width bits and clears the rest. With `use_reg`=1 it reverses the byte order within the low width bits and clears the rest.
- R7: UDIV and UREM are unsigned. A zero divisor gives 0 for UDIV and returns the dividend unchanged for UREM.
- R8: When `ext_en`=1, SDIV and SREM are signed. The quotient truncates toward zero and the remainder takes the sign of the dividend. A zero divisor gives 0 for SDIV and returns the dividend for SREM. The most negative value divided by -1 gives the most negative value.
- R9: The request is illegal in three cases: SDIV or SREM with `ext_en`=0, BSWAP in the 64-bit class, and BSWAP with a width other than 16, 32 or 64. An illegal request completes one cycle after acceptance with `illegal`=1 and `result`=0.
- R10: A non-divide or illegal request completes one cycle after the accepting edge. A legal divide request completes 66 cycles after it in the 64-bit class and 34 cycles after it in the 32-bit class. `done` is high for exactly one cycle per accepted request.
- R11: While a divide is in progress, `start` is ignored. The divide completes at its normal time with its own result, and no extra completion follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a request; accepted when no divide is in progress |
| op_code | input | 4 | Operation selector |
| use_reg | input | 1 | 1: second operand is src_val; 0: immediate. For BSWAP, 1 chooses byte reversal |
| wide | input | 1 | 1: 64-bit class; 0: 32-bit class |
| dst_val | input | 64 | Destination register value (first operand) |
| src_val | input | 64 | Source register value |
| imm_val | input | 32 | Immediate; byte-order conversion width for BSWAP |
| ext_en | input | 1 | Enables the signed divide and remainder |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Result of the last completed request |
| illegal | output | 1 | Last completed request was illegal |

## Verification
The properties assume that the operand, mode and operation inputs are sampled only on the accepting edge. They also assume that `start` may stay high or toggle at will while a divide is in progress, and the bench drives exactly that case to show it has no effect. Random requests draw every operation code, both classes and both operand sources. The immediate for byte-order conversion is drawn mostly from the three legal widths, with occasional other values. Zero divisors, the signed overflow case, out-of-range shift counts and the illegal combinations are also driven directly, so that the boundary values named in the requirements are reached every run.

// File: rtl/vmx_alu_pkg.sv
package vmx_alu_pkg;
   typedef enum logic [3:0] {
      OP_ADD   = 4'h0,
      OP_SUB   = 4'h1,
      OP_MUL   = 4'h2,
      OP_UDIV  = 4'h3,
      OP_IOR   = 4'h4,
      OP_AND   = 4'h5,
      OP_SHL   = 4'h6,
      OP_SHR   = 4'h7,
      OP_NEG   = 4'h8,
      OP_UREM  = 4'h9,
      OP_XOR   = 4'hA,
      OP_COPY  = 4'hB,
      OP_SAR   = 4'hC,
      OP_BSWAP = 4'hD,
      OP_SQUO  = 4'hE,
      OP_SREM  = 4'hF
   } op_e;

   typedef enum logic [1:0] {
      SW_16 = 2'd0,
      SW_32 = 2'd1,
      SW_64 = 2'd2
   } swap_w_e;
endpackage

// File: rtl/vmx_alu_logic.sv
module vmx_alu_logic
   import vmx_alu_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  op_e             op,
   input  logic            wide,
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   output logic [XLEN-1:0] res
);
   localparam int HALF = XLEN / 2;
   localparam int SH_W = $clog2(XLEN);

   logic [SH_W-1:0] amt;
   logic [XLEN-1:0] a_log;
   logic [XLEN-1:0] a_ari;
   logic [XLEN-1:0] full;

   assign amt   = wide ? opb[SH_W-1:0] : {1'b0, opb[SH_W-2:0]};
   assign a_log = wide ? opa : {{HALF{1'b0}}, opa[HALF-1:0]};
   assign a_ari = wide ? opa : {{HALF{opa[HALF-1]}}, opa[HALF-1:0]};

   always_comb begin
      case (op)
         OP_ADD:  full = opa + opb;
         OP_SUB:  full = opa - opb;
         OP_MUL:  full = opa * opb;
         OP_IOR:  full = opa | opb;
         OP_AND:  full = opa & opb;
         OP_XOR:  full = opa ^ opb;
         OP_COPY: full = opb;
         OP_NEG:  full = -opa;
         OP_SHL:  full = opa << amt;
         OP_SHR:  full = a_log >> amt;
         OP_SAR:  full = $unsigned($signed(a_ari) >>> amt);
         default: full = '0;
      endcase
   end

   assign res = wide ? full : {{HALF{1'b0}}, full[HALF-1:0]};
endmodule

// File: rtl/vmx_alu_bswap.sv
module vmx_alu_bswap
   import vmx_alu_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] val,
   input  swap_w_e         sel,
   input  logic            to_big,
   output logic [XLEN-1:0] res
);
   localparam int NB = XLEN / 8;

   logic [XLEN-1:0] s64;
   logic [XLEN-1:0] s32;
   logic [XLEN-1:0] s16;

   for (genvar i = 0; i < NB; i++) begin : g_byte
      assign s64[8*i +: 8] = val[8*(NB-1-i) +: 8];
      if (i < 4) begin : g_w32
         assign s32[8*i +: 8] = val[8*(3-i) +: 8];
      end else begin : g_z32
         assign s32[8*i +: 8] = 8'h00;
      end
      if (i < 2) begin : g_w16
         assign s16[8*i +: 8] = val[8*(1-i) +: 8];
      end else begin : g_z16
         assign s16[8*i +: 8] = 8'h00;
      end
   end

   always_comb begin
      case (sel)
         SW_16:   res = to_big ? s16 : {{(XLEN-16){1'b0}}, val[15:0]};
         SW_32:   res = to_big ? s32 : {{(XLEN-32){1'b0}}, val[31:0]};
         default: res = to_big ? s64 : val;
      endcase
   end
endmodule

// File: rtl/vmx_alu_div.sv
module vmx_alu_div #(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            sgn,
   input  logic            narrow,
   input  logic [XLEN-1:0] dividend,
   input  logic [XLEN-1:0] divisor,
   output logic            fin,
   output logic [XLEN-1:0] quo,
   output logic [XLEN-1:0] rem
);
   localparam int HALF  = XLEN / 2;
   localparam int CNT_W = $clog2(XLEN + 1);

   logic [CNT_W-1:0] cnt;
   logic [XLEN-1:0]  q;
   logic [XLEN-1:0]  r;
   logic [XLEN-1:0]  d;
   logic [XLEN-1:0]  orig_a;
   logic             neg_q;
   logic             neg_r;
   logic             zero_d;

   logic [XLEN-1:0]  a_ext;
   logic [XLEN-1:0]  b_ext;
   logic             a_neg;
   logic             b_neg;
   logic [XLEN:0]    r_sh;
   logic             ge;
   logic [XLEN:0]    r_nx;

   always_comb begin
      if (narrow) begin
         a_ext = sgn ? {{HALF{dividend[HALF-1]}}, dividend[HALF-1:0]}
                     : {{HALF{1'b0}}, dividend[HALF-1:0]};
         b_ext = sgn ? {{HALF{divisor[HALF-1]}}, divisor[HALF-1:0]}
                     : {{HALF{1'b0}}, divisor[HALF-1:0]};
      end else begin
         a_ext = dividend;
         b_ext = divisor;
      end
   end

   assign a_neg = sgn & a_ext[XLEN-1];
   assign b_neg = sgn & b_ext[XLEN-1];
   assign r_sh  = {r, q[XLEN-1]};
   assign ge    = r_sh >= {1'b0, d};
   assign r_nx  = ge ? (r_sh - {1'b0, d}) : r_sh;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         q      <= '0;
         r      <= '0;
         d      <= '0;
         orig_a <= '0;
         neg_q  <= 1'b0;
         neg_r  <= 1'b0;
         zero_d <= 1'b0;
         fin    <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (load) begin
            cnt    <= narrow ? CNT_W'(HALF) : CNT_W'(XLEN);
            q      <= (a_neg ? -a_ext : a_ext) << (narrow ? HALF : 0);
            r      <= '0;
            d      <= b_neg ? -b_ext : b_ext;
            orig_a <= a_ext;
            neg_q  <= a_neg ^ b_neg;
            neg_r  <= a_neg;
            zero_d <= (b_ext == '0);
         end else if (cnt != '0) begin
            q   <= {q[XLEN-2:0], ge};
            r   <= r_nx[XLEN-1:0];
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) fin <= 1'b1;
         end
      end
   end

   assign quo = zero_d ? '0 : (neg_q ? -q : q);
   assign rem = zero_d ? orig_a : (neg_r ? -r : r);
endmodule

// File: rtl/vmx_int_alu.sv
module vmx_int_alu
   import vmx_alu_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int IMM_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [3:0]       op_code,
   input  logic             use_reg,
   input  logic             wide,
   input  logic [XLEN-1:0]  dst_val,
   input  logic [XLEN-1:0]  src_val,
   input  logic [IMM_W-1:0] imm_val,
   input  logic             ext_en,
   output logic             done,
   output logic [XLEN-1:0]  result,
   output logic             illegal
);
   localparam int HALF = XLEN / 2;

   if (XLEN != 64) begin : g_bad_xlen
      $error("vmx_int_alu: byte-order widths require XLEN of 64");
   end
   if (IMM_W != HALF) begin : g_bad_imm
      $error("vmx_int_alu: immediate must be half the data width");
   end

   op_e             op;
   logic [XLEN-1:0] imm_ext;
   logic [XLEN-1:0] opnd_b;
   swap_w_e         sw_sel;
   logic            sw_ok;
   logic            sgn_div;
   logic            bad_op;
   logic            div_op;
   logic            busy_q;
   logic            want_rem_q;
   logic            narrow_q;
   logic [XLEN-1:0] logic_res;
   logic [XLEN-1:0] swap_res;
   logic            div_fin;
   logic [XLEN-1:0] div_quo;
   logic [XLEN-1:0] div_rem;
   logic [XLEN-1:0] div_pick;

   assign op      = op_e'(op_code);
   assign imm_ext = wide ? {{(XLEN-IMM_W){imm_val[IMM_W-1]}}, imm_val}
                         : {{(XLEN-IMM_W){1'b0}}, imm_val};
   assign opnd_b  = use_reg ? src_val : imm_ext;

   always_comb begin
      sw_ok  = 1'b1;
      case (imm_val)
         IMM_W'(16): sw_sel = SW_16;
         IMM_W'(32): sw_sel = SW_32;
         IMM_W'(64): sw_sel = SW_64;
         default: begin
            sw_sel = SW_64;
            sw_ok  = 1'b0;
         end
      endcase
   end

   assign sgn_div = (op == OP_SQUO) || (op == OP_SREM);
   assign bad_op  = (sgn_div && !ext_en) || ((op == OP_BSWAP) && (wide || !sw_ok));
   assign div_op  = !bad_op && ((op == OP_UDIV) || (op == OP_UREM) || sgn_div);

   vmx_alu_logic #(.XLEN(XLEN)) u_logic (
      .op   (op),
      .wide (wide),
      .opa  (dst_val),
      .opb  (opnd_b),
      .res  (logic_res)
   );

   vmx_alu_bswap #(.XLEN(XLEN)) u_swap (
      .val    (dst_val),
      .sel    (sw_sel),
      .to_big (use_reg),
      .res    (swap_res)
   );

   vmx_alu_div #(.XLEN(XLEN)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start && !busy_q && div_op),
      .sgn      (sgn_div),
      .narrow   (!wide),
      .dividend (dst_val),
      .divisor  (opnd_b),
      .fin      (div_fin),
      .quo      (div_quo),
      .rem      (div_rem)
   );

   assign div_pick = want_rem_q ? div_rem : div_quo;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done       <= 1'b0;
         result     <= '0;
         illegal    <= 1'b0;
         busy_q     <= 1'b0;
         want_rem_q <= 1'b0;
         narrow_q   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (busy_q) begin
            if (div_fin) begin
               busy_q  <= 1'b0;
               done    <= 1'b1;
               illegal <= 1'b0;
               result  <= narrow_q ? {{HALF{1'b0}}, div_pick[HALF-1:0]} : div_pick;
            end
         end else if (start) begin
            if (div_op) begin
               busy_q     <= 1'b1;
               want_rem_q <= (op == OP_UREM) || (op == OP_SREM);
               narrow_q   <= !wide;
            end else begin
               done    <= 1'b1;
               illegal <= bad_op;
               if (bad_op)               result <= '0;
               else if (op == OP_BSWAP)  result <= swap_res;
               else                      result <= logic_res;
            end
         end
      end
   end
endmodule

// File: rtl/vmx_int_alu_chk.sv
module vmx_int_alu_chk #(
   parameter int XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic [3:0]      op_code,
   input logic            wide,
   input logic            ext_en,
   input logic            done,
   input logic [XLEN-1:0] result,
   input logic            illegal,
   input logic            busy
);
   localparam int HALF = XLEN / 2;

   logic accept;
   logic slow;
   logic pend;
   logic last_wide;
   logic last_swap;

   assign accept = start && !busy;
   assign slow   = (op_code == 4'h3) || (op_code == 4'h9) ||
                   ((op_code >= 4'hE) && ext_en);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         last_wide <= 1'b0;
         last_swap <= 1'b0;
      end else begin
         if (accept) begin
            pend      <= 1'b1;
            last_wide <= wide;
            last_swap <= (op_code == 4'hD);
         end else if (done) begin
            pend <= 1'b0;
         end
      end
   end

   AST_FAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !slow |=> done);                                        // R10
   AST_DIV_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      accept && slow |=> busy && !done);                                // R10
   AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> pend);                                                   // R11
   AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      done && illegal |-> result == '0);                                // R9
   AST_SIGNED_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (op_code >= 4'hE) && !ext_en |=> done && illegal);      // R8
   AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
      done && !illegal && !last_wide && !last_swap
      |-> result[XLEN-1:HALF] == '0);                                   // R4
endmodule

bind vmx_int_alu vmx_int_alu_chk #(.XLEN(XLEN)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .op_code (op_code),
   .wide    (wide),
   .ext_en  (ext_en),
   .done    (done),
   .result  (result),
   .illegal (illegal),
   .busy    (busy_q)
);

// File: tb/test_vmx_int_alu.sv
`timescale 1ns/1ps
module test_vmx_int_alu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  op_code = '0;
   logic        use_reg = 1'b0;
   logic        wide = 1'b0;
   logic [63:0] dst_val = '0;
   logic [63:0] src_val = '0;
   logic [31:0] imm_val = '0;
   logic        ext_en = 1'b0;
   logic        done;
   logic [63:0] result;
   logic        illegal;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   vmx_int_alu i_vmx_int_alu (
      .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
      .use_reg(use_reg), .wide(wide), .dst_val(dst_val), .src_val(src_val),
      .imm_val(imm_val), .ext_en(ext_en), .done(done), .result(result),
      .illegal(illegal)
   );

   task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic void model(input logic [3:0] op, input logic ur, input logic wd,
                                 input logic [63:0] d, input logic [63:0] s,
                                 input logic [31:0] im, input logic ex,
                                 output logic ill, output logic [63:0] res);
      logic [63:0] a, b, sa, sb, ma, mb, q, r;
      logic na, nb;
      int nby;
      b = ur ? s : (wd ? {{32{im[31]}}, im} : {32'h0, im});
      a = d;
      if (!wd) begin
         a = a & 64'hFFFF_FFFF;
         b = b & 64'hFFFF_FFFF;
      end
      ill = ((op >= 4'hE) && !ex) ||
            ((op == 4'hD) && (wd || !(im == 16 || im == 32 || im == 64)));
      res = '0;
      if (!ill) begin
         case (op)
            4'h0: res = a + b;
            4'h1: res = a - b;
            4'h2: res = a * b;
            4'h4: res = a | b;
            4'h5: res = a & b;
            4'hA: res = a ^ b;
            4'hB: res = b;
            4'h8: res = -a;
            4'h6: res = wd ? (a << b[5:0]) : (a << b[4:0]);
            4'h7: res = wd ? (a >> b[5:0]) : (a >> b[4:0]);
            4'hC: res = wd ? $unsigned($signed(a) >>> b[5:0])
                           : $unsigned($signed({{32{a[31]}}, a[31:0]}) >>> b[4:0]);
            4'h3: res = (b == 0) ? 64'h0 : a / b;
            4'h9: res = (b == 0) ? a : a % b;
            4'hE, 4'hF: begin
               sa = wd ? a : {{32{a[31]}}, a[31:0]};
               sb = wd ? b : {{32{b[31]}}, b[31:0]};
               if (sb == 0) res = (op == 4'hE) ? 64'h0 : sa;
               else begin
                  na = sa[63];
                  nb = sb[63];
                  ma = na ? -sa : sa;
                  mb = nb ? -sb : sb;
                  q = ma / mb;
                  r = ma % mb;
                  res = (op == 4'hE) ? ((na ^ nb) ? -q : q) : (na ? -r : r);
               end
            end
            4'hD: begin
               nby = im / 8;
               if (!ur) res = (im == 64) ? d : (d & ((64'd1 << im) - 64'd1));
               else for (int i = 0; i < nby; i++) res[8*i +: 8] = d[8*(nby-1-i) +: 8];
            end
            default: res = '0;
         endcase
      end
      if (!wd && op != 4'hD) res = res & 64'hFFFF_FFFF;
   endfunction

   function automatic string op_tag(input logic [3:0] op, input logic wd);
      string t;
      case (op)
         4'h3, 4'h9: t = "R7";
         4'hE, 4'hF: t = "R8";
         4'h6, 4'h7, 4'hC: t = "R5";
         4'hD: t = "R6";
         default: t = "R3";
      endcase
      if (!wd) t = {t, "/R4"};
      return t;
   endfunction

   task automatic do_op(input logic [3:0] op, input logic ur, input logic wd,
                        input logic [63:0] d, input logic [63:0] s,
                        input logic [31:0] im, input logic ex, input string tag);
      logic eill;
      logic [63:0] eres;
      int lat, elat;
      model(op, ur, wd, d, s, im, ex, eill, eres);
      elat = (!eill && (op == 4'h3 || op == 4'h9 || op >= 4'hE)) ? (wd ? 66 : 34) : 1;
      @(negedge clk);
      op_code = op; use_reg = ur; wide = wd; dst_val = d; src_val = s;
      imm_val = im; ext_en = ex; start = 1'b1;
      lat = 0;
      while (1) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         start = 1'b0;
         if (done) break;
         if (lat > 200) break;
      end
      chk(result == eres, {tag, " result"}, result, eres);
      chk(illegal == eill, {tag, "/R9 illegal"}, 64'(illegal), 64'(eill));
      chk(lat == elat, {tag, "/R10 latency"}, 64'(lat), 64'(elat));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int seed;
      logic eill;
      logic [63:0] eres;
      int lat;
      seed = $urandom(32'd7121);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(done == 1'b0, "R1 done", 64'(done), 64'h0);
      chk(illegal == 1'b0, "R1 illegal", 64'(illegal), 64'h0);
      chk(result == 64'h0, "R1 result", result, 64'h0);
      rst_n = 1'b1;

      // R2 operand selection and immediate sign extension
      do_op(4'h0, 1'b0, 1'b1, 64'd5, 64'd100, 32'hFFFF_FFFD, 1'b0, "R2 add imm");
      do_op(4'h0, 1'b1, 1'b1, 64'd5, 64'd100, 32'hFFFF_FFFD, 1'b0, "R2 add reg");
      do_op(4'hB, 1'b0, 1'b0, 64'h1234, 64'd0, 32'h8000_0000, 1'b0, "R2 copy narrow imm");
      // R3 / R4
      do_op(4'h8, 1'b1, 1'b1, 64'd1, 64'd9, 32'd0, 1'b0, "R3 neg");
      do_op(4'h0, 1'b1, 1'b0, 64'hAAAA_0000_FFFF_FFFF, 64'd2, 32'd0, 1'b0, "R4 add wrap");
      // R5 shift masking
      do_op(4'h6, 1'b0, 1'b1, 64'h3, 64'd0, 32'd65, 1'b0, "R5 shl mask6");
      do_op(4'h7, 1'b0, 1'b0, 64'hFFFF_FFFF_8000_0000, 64'd0, 32'd33, 1'b0, "R5 shr mask5");
      do_op(4'hC, 1'b0, 1'b0, 64'h0000_0000_8000_0000, 64'd0, 32'd4, 1'b0, "R5 sar narrow");
      do_op(4'hC, 1'b1, 1'b1, 64'h8000_0000_0000_0000, 64'd63, 32'd0, 1'b0, "R5 sar wide");
      // R6 byte order
      do_op(4'hD, 1'b0, 1'b0, 64'h1122_3344_5566_7788, 64'd0, 32'd16, 1'b0, "R6 keep16");
      do_op(4'hD, 1'b1, 1'b0, 64'h1122_3344_5566_7788, 64'd0, 32'd32, 1'b0, "R6 swap32");
      do_op(4'hD, 1'b1, 1'b0, 64'h1122_3344_5566_7788, 64'd0, 32'd64, 1'b0, "R6 swap64");
      do_op(4'hD, 1'b1, 1'b0, 64'h1122_3344_5566_7788, 64'd0, 32'd8, 1'b0, "R9 bad width");
      do_op(4'hD, 1'b0, 1'b1, 64'h1122_3344_5566_7788, 64'd0, 32'd16, 1'b0, "R9 swap wide");
      // R7 / R8 divide corners
      do_op(4'h3, 1'b1, 1'b1, 64'd77, 64'd0, 32'd0, 1'b0, "R7 udiv by zero");
      do_op(4'h9, 1'b1, 1'b0, 64'hDEAD_BEEF_1234_5678, 64'hF_0000_0000, 32'd0, 1'b0, "R7 urem by zero narrow");
      do_op(4'h3, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 64'd0, 32'd7, 1'b0, "R7 udiv");
      do_op(4'hE, 1'b0, 1'b1, -64'sd7, 64'd0, 32'd2, 1'b1, "R8 sdiv");
      do_op(4'hF, 1'b0, 1'b1, -64'sd7, 64'd0, 32'd2, 1'b1, "R8 srem");
      do_op(4'hE, 1'b1, 1'b1, 64'h8000_0000_0000_0000, -64'sd1, 32'd0, 1'b1, "R8 min by -1");
      do_op(4'hF, 1'b1, 1'b0, 64'h0000_0000_FFFF_FFF9, 64'd0, 32'd0, 1'b1, "R8 srem by zero narrow");
      do_op(4'hE, 1'b1, 1'b0, 64'h0000_0000_FFFF_FFF9, 64'd3, 32'd0, 1'b1, "R8 sdiv narrow");
      do_op(4'hE, 1'b1, 1'b1, 64'd100, 64'd3, 32'd0, 1'b0, "R9 sdiv no ext");

      // R11 start ignored while a divide runs
      model(4'h3, 1'b1, 1'b1, 64'd1000, 64'd7, 32'd0, 1'b0, eill, eres);
      @(negedge clk);
      op_code = 4'h3; use_reg = 1'b1; wide = 1'b1; dst_val = 64'd1000;
      src_val = 64'd7; ext_en = 1'b0; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      op_code = 4'h0; dst_val = 64'd1; src_val = 64'd1;
      lat = 1;
      while (1) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         if (lat > 20) start = 1'b0;
         if (done || lat > 200) break;
      end
      start = 1'b0;
      chk(lat == 66, "R11 latency with start held", 64'(lat), 64'd66);
      chk(result == eres, "R11 result with start held", result, eres);
      @(negedge clk);
      chk(done == 1'b0, "R11 no extra done", 64'(done), 64'h0);

      // random mix
      for (int k = 0; k < 300; k++) begin
         logic [3:0] op;
         logic ur, wd, ex;
         logic [63:0] d, s;
         logic [31:0] im;
         op = 4'($urandom % 16);
         ur = 1'($urandom);
         wd = 1'($urandom);
         ex = ($urandom % 4) != 0;
         d = {$urandom, $urandom};
         s = {$urandom, $urandom};
         im = $urandom;
         if ($urandom % 4 == 0) s = 64'($urandom % 8);
         if ($urandom % 4 == 0) im = $urandom % 8;
         if (op == 4'hD) begin
            wd = ($urandom % 5) == 0;
            case ($urandom % 4)
               0: im = 32'd16;
               1: im = 32'd32;
               2: im = 32'd64;
               default: im = $urandom % 80;
            endcase
         end
         do_op(op, ur, wd, d, s, im, ex, op_tag(op, wd));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule